// File: doc/BRIEF.md
# Paged Address Translator with Lock/Key Protection

The block turns a 16-bit logical word address into a 20-bit physical address. Memory is split into pages of 4K words. A file of 512 page registers supplies the upper physical bits. The register is chosen by three things: a 4-bit address state, a flag that separates instruction fetches from operand accesses, and the top four bits of the logical address. That gives 16 sets, each holding one operand group and one instruction group of 16 registers.

Each register holds an 8-bit physical page number, a 4-bit access lock and one inhibit bit. On every strobed access the processor key is checked against the lock, and the inhibit bit is checked against the kind of access. A violation pulls an active-low fault output low one cycle later. A privileged load port rewrites any register by index.

After reset the whole table maps one to one and imposes no restriction. Software then reshapes the map and the protection through the load port.

Top module: `mmu_lockkey`

## Requirements
- R1: Bits 11:0 of `phys_addr` always equal bits 11:0 of `acc_laddr`.
- R2: Bits 19:12 of `phys_addr` are bits 7:0 of the register at index {`acc_state`, `acc_ifetch`, `acc_laddr[15:12]`}. The index is 9 bits, with `acc_state` in bits 8:5, `acc_ifetch` in bit 4 and the page in bits 3:0. This output is combinational.
- R3: Operand accesses (`acc_ifetch`=0) and instruction fetches (`acc_ifetch`=1) with the same state and page use different registers.
- R4: After reset every register holds page number {index[8:5], index[3:0]}, lock 4'hF and inhibit 0, so no access faults.
- R5: The lock check passes when the key is 0, when the key equals the lock, or when the lock is 4'hF. Any other key faults.
- R6: When inhibit is set, an operand write (`acc_ifetch`=0, `acc_write`=1) faults and so does any fetch (`acc_ifetch`=1). An operand read is not blocked by the inhibit bit.
- R7: `fault_n` is registered. In the cycle after a strobed access it is 0 exactly when R5 or R6 is violated. It is 1 in the cycle after any cycle with `acc_valid`=0, and it is 1 out of reset.
- R8: `ld_en` writes `ld_data` to register `ld_idx` at the clock edge. The data layout is bit 12 = inhibit, bits 11:8 = lock, bits 7:0 = page. A lookup in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_state | input | 4 | Address state, selects the set |
| acc_key | input | 4 | Processor access key |
| acc_ifetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| acc_write | input | 1 | 1 = write |
| acc_laddr | input | 16 | Logical word address |
| phys_addr | output | 20 | Physical word address |
| fault_n | output | 1 | Registered protection fault, active low |
| ld_en | input | 1 | Register load enable |
| ld_idx | input | 9 | Register index to load |
| ld_data | input | 13 | Register contents to load |

## Verification
The first pattern sweeps states, pages and keys across the untouched identity table. It tells a correct reset image apart from a wrong index layout or a lock that is not reset to the wildcard. The next pattern loads chosen locks and keys, covering an exact match, key 0, lock F and a mismatch, and separates each arm of the key rule. Inhibit bits are then tried with reads, writes and fetches in both spaces, which shows whether the protection is steered by space. The last pattern loads a register and looks it up in the same cycle, which exposes a write-through path that should not exist.

// File: rtl/mmu_lockkey.sv
module mmu_lockkey #(
  parameter int SET_W  = 4,
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 12,
  parameter int PPA_W  = 8,
  parameter int LOCK_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic [SET_W-1:0]          acc_state,
  input  logic [LOCK_W-1:0]         acc_key,
  input  logic                      acc_ifetch,
  input  logic                      acc_write,
  input  logic [PAGE_W+OFS_W-1:0]   acc_laddr,
  output logic [PPA_W+OFS_W-1:0]    phys_addr,
  output logic                      fault_n,
  input  logic                      ld_en,
  input  logic [SET_W+PAGE_W:0]     ld_idx,
  input  logic [PPA_W+LOCK_W:0]     ld_data
);
  localparam int IDX_W = SET_W + 1 + PAGE_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int DW    = PPA_W + LOCK_W + 1;
  localparam int LA_W  = PAGE_W + OFS_W;

  logic [DW-1:0]     tbl [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [DW-1:0]     ent;
  logic [LOCK_W-1:0] lock;
  logic              inhibit, key_ok, blocked;

  assign idx     = {acc_state, acc_ifetch, acc_laddr[LA_W-1:OFS_W]};
  assign ent     = tbl[idx];
  assign lock    = ent[PPA_W +: LOCK_W];
  assign inhibit = ent[DW-1];
  assign key_ok  = (acc_key == '0) || (lock == '1) || (acc_key == lock);
  assign blocked = inhibit && (acc_ifetch || acc_write);
  assign phys_addr = {ent[PPA_W-1:0], acc_laddr[OFS_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl[i] <= {1'b0, {LOCK_W{1'b1}},
                   PPA_W'(((i >> (PAGE_W + 1)) << PAGE_W) | (i % (1 << PAGE_W)))};
      end
    end else if (ld_en) begin
      tbl[ld_idx] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_n <= 1'b1;
    else        fault_n <= !(acc_valid && (!key_ok || blocked));
  end
endmodule

module mmu_lockkey_chk #(
  parameter int SET_W  = 4,
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 12,
  parameter int PPA_W  = 8,
  parameter int LOCK_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic [SET_W-1:0]        acc_state,
  input logic [LOCK_W-1:0]       acc_key,
  input logic                    acc_ifetch,
  input logic                    acc_write,
  input logic [PAGE_W+OFS_W-1:0] acc_laddr,
  input logic [PPA_W+OFS_W-1:0]  phys_addr,
  input logic                    fault_n,
  input logic                    ld_en
);
  localparam int LA_W = PAGE_W + OFS_W;
  localparam int PA_W = PPA_W + OFS_W;
  logic touched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     touched <= 1'b0;
    else if (ld_en) touched <= 1'b1;
  end

  a_r1_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == acc_laddr[OFS_W-1:0]);

  a_r4_identity_map: assert property (@(posedge clk) disable iff (!rst_n)
    !touched |-> phys_addr[PA_W-1:OFS_W] == PPA_W'({acc_state, acc_laddr[LA_W-1:OFS_W]}));

  a_r4_no_fault_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (!touched && acc_valid) |=> fault_n);

  a_r5_key_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_key == '0 && !acc_write && !acc_ifetch) |=> fault_n);

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> fault_n);
endmodule

bind mmu_lockkey mmu_lockkey_chk #(
  .SET_W(SET_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .PPA_W(PPA_W), .LOCK_W(LOCK_W)
) chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_state(acc_state),
  .acc_key(acc_key), .acc_ifetch(acc_ifetch), .acc_write(acc_write),
  .acc_laddr(acc_laddr), .phys_addr(phys_addr), .fault_n(fault_n), .ld_en(ld_en)
);

// File: tb/mmu_lockkey_test.sv
module mmu_lockkey_test;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_ifetch = 0, acc_write = 0, ld_en = 0;
  logic [3:0] acc_state = 0, acc_key = 0;
  logic [15:0] acc_laddr = 0;
  logic [19:0] phys_addr;
  logic fault_n;
  logic [8:0] ld_idx = 0;
  logic [12:0] ld_data = 0;
  int tests = 0, fails = 0;
  logic [12:0] mdl [512];

  always #5 clk = ~clk;

  mmu_lockkey uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [8:0] ix;
    logic [12:0] e;
    logic ok, expf;
    #1;
    ix = {acc_state, acc_ifetch, acc_laddr[15:12]};
    e = mdl[ix];
    chk({tag, " phys"}, 32'(phys_addr), 32'({e[7:0], acc_laddr[11:0]}));
    ok = (acc_key == 0) || (e[11:8] == 4'hF) || (acc_key == e[11:8]);
    expf = !(acc_valid && (!ok || (e[12] && (acc_ifetch || acc_write))));
    @(posedge clk);
    if (ld_en) mdl[ld_idx] = ld_data;
    @(negedge clk);
    chk({tag, " fault"}, 32'(fault_n), 32'(expf));
  endtask

  task automatic acc(input logic [3:0] st, key, input logic ifc, wr,
                     input logic [15:0] la, input string tag);
    acc_valid = 1; acc_state = st; acc_key = key; acc_ifetch = ifc;
    acc_write = wr; acc_laddr = la; ld_en = 0;
    step(tag);
  endtask

  task automatic load(input logic [8:0] ix, input logic [12:0] d);
    acc_valid = 0; ld_en = 1; ld_idx = ix; ld_data = d;
    step("R8 load");
    ld_en = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = {1'b0, 4'hF, 8'((i >> 5) << 4 | (i & 15))};
    #12 rst_n = 1;
    @(negedge clk);
    chk("R7 reset fault_n", 32'(fault_n), 1);
    // R4 R1 R2: identity sweep with random keys, offsets, kinds
    for (int i = 0; i < 64; i++)
      acc(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), "R4");
    // R7 idle cycles
    acc_valid = 0; acc_key = 4'h5;
    for (int i = 0; i < 4; i++) step("R7 idle");
    // R5 lock 7 on set 2 operand page 3
    load({4'd2, 1'b0, 4'd3}, {1'b0, 4'h7, 8'hA5});
    acc(4'd2, 4'h7, 0, 0, 16'h3123, "R5 match");
    acc(4'd2, 4'h0, 0, 1, 16'h3FFF, "R5 key zero");
    acc(4'd2, 4'h6, 0, 0, 16'h3000, "R5 mismatch");
    acc(4'd2, 4'hF, 0, 0, 16'h3001, "R5 key F on lock 7");
    // R3: instruction twin untouched
    acc(4'd2, 4'h6, 1, 0, 16'h3456, "R3 ifetch twin");
    // R6 inhibit on operand page
    load({4'd9, 1'b0, 4'd0}, {1'b1, 4'hF, 8'h11});
    acc(4'd9, 4'h3, 0, 0, 16'h0ABC, "R6 operand read");
    acc(4'd9, 4'h3, 0, 1, 16'h0ABC, "R6 operand write");
    // R6 inhibit on instruction page
    load({4'd9, 1'b1, 4'd0}, {1'b1, 4'h4, 8'h22});
    acc(4'd9, 4'h4, 1, 0, 16'h0123, "R6 fetch inhibited");
    acc(4'd9, 4'h4, 0, 0, 16'h0123, "R3 operand unaffected");
    // R2: remapped page numbers
    load({4'd15, 1'b1, 4'd15}, {1'b0, 4'h2, 8'h3C});
    acc(4'd15, 4'h2, 1, 0, 16'hF777, "R2 remap");
    acc(4'd15, 4'h9, 1, 0, 16'hF777, "R5 wrong key remap");
    // R8 load and lookup same cycle
    acc_valid = 1; acc_state = 4'd4; acc_key = 4'h1; acc_ifetch = 0;
    acc_write = 0; acc_laddr = 16'h8008;
    ld_en = 1; ld_idx = {4'd4, 1'b0, 4'd8}; ld_data = {1'b0, 4'h3, 8'hEE};
    step("R8 same cycle old");
    ld_en = 0;
    step("R8 next cycle new");
    // random mix
    for (int i = 0; i < 200; i++) begin
      if (i % 5 == 0) load(9'($urandom), 13'($urandom));
      else acc(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
               16'($urandom), "R5 R6 mix");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule